// File: doc/BRIEF.md
# Multi-Policy Cache Victim Selector

This block chooses which way of a set-associative cache is overwritten when a miss has to install a new line. For every set it keeps replacement state that records how recently each way was touched and the order in which the ways were filled. A two-bit mode input picks one of four policies: least recently touched, most recently touched, oldest fill, or pseudo-random. The policy can be changed at any time without clearing the state. Tags, line data and memory traffic belong to the surrounding cache.

The cache controller presents one access per cycle with `acc_valid` and the set index. The index is the block address modulo the number of sets. `hit` with `hit_way` reports a hit. `fill` reports that the miss line is being installed into the way shown on `victim_way` in that same cycle. `way_valid` carries the valid bits of the addressed set. `victim_way` is combinational from the stored state of the addressed set, the valid bits, the mode and a free-running pseudo-random source. A way that is not valid is always chosen ahead of a valid one. With one way per set the output is constant zero and no state is kept.

Top module: `victim_sel`

## Requirements
- R1: With WAYS = 1, `victim_way` is always 0, whatever the inputs.
- R2: When any bit of `way_valid` is 0, `victim_way` is the lowest-numbered way whose valid bit is 0. This holds in every mode.
- R3: In mode 0 (least recently used) with all ways valid, `victim_way` is the way of the addressed set touched longest ago. A hit touches `hit_way`. A fill without a hit touches the way shown on `victim_way` in that cycle.
- R4: In mode 1 (most recently used) with all ways valid, `victim_way` is the way of the addressed set touched most recently, with touches defined as in R3.
- R5: In mode 2 (first in, first out) with all ways valid, `victim_way` is the way of the addressed set filled longest ago. Hits leave this order unchanged.
- R6: In mode 3 (random) with all ways valid, `victim_way` is taken from a free-running 16-bit LFSR. Over 4096 consecutive cycles each of the 4 ways is chosen between 820 and 1230 times.
- R7: After reset every set behaves as if the ways were touched and filled in ascending order. Way 0 is the oldest and way WAYS-1 the newest, so modes 0 and 2 give 0 and mode 1 gives WAYS-1.
- R8: A change of `mode` applies to the victim in the same cycle and uses the state built up under the earlier mode. Touch order and fill order are both kept up to date in every mode.
- R9: Replacement state is kept per set. An access to one set leaves the victim of every other set unchanged.
- R10: While `acc_valid` is 0, `hit` and `fill` are ignored and no state changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Policy: 0 LRU, 1 MRU, 2 FIFO, 3 random |
| acc_valid | input | 1 | Access strobe qualifying hit and fill |
| acc_set | input | log2(SETS) | Set index of the access |
| hit | input | 1 | Access hit in the cache |
| hit_way | input | log2(WAYS) | Way that hit |
| fill | input | 1 | Miss line installed into `victim_way` this cycle |
| way_valid | input | WAYS | Valid bits of the addressed set |
| victim_way | output | log2(WAYS) | Way to replace in the addressed set |

## Verification
The hardest situation to reach is a set whose touch order and fill order disagree, because only then do LRU and FIFO give different victims. The stimulus builds that state with an arithmetic pattern of hits and fills over every set. It then switches the mode on an unchanged set and compares the victim against timestamp models kept in the bench. The invalid-way priority is swept over every incomplete valid pattern in all four modes. The random policy is judged by counting its choices over a long idle window.

// File: rtl/victim_pkg.sv
package victim_pkg;
  typedef enum logic [1:0] {
    POL_LRU  = 2'd0,
    POL_MRU  = 2'd1,
    POL_FIFO = 2'd2,
    POL_RAND = 2'd3
  } repl_mode_e;
endpackage

// File: rtl/rank_store.sv
// Per-set age ranks: rank 0 is the newest way, rank WAYS-1 the oldest.
module rank_store #(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  localparam int RW = ($clog2(WAYS) > 0) ? $clog2(WAYS) : 1,
  localparam int SW = ($clog2(SETS) > 0) ? $clog2(SETS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               upd_en,
  input  logic [SW-1:0]      upd_set,
  input  logic [RW-1:0]      upd_way,
  input  logic [SW-1:0]      rd_set,
  output logic [WAYS*RW-1:0] rd_ranks
);
  logic [RW-1:0] rank_q [SETS][WAYS];
  logic [RW-1:0] row_d  [WAYS];
  logic [RW-1:0] touched;

  // next-state for the updated row: younger ways age, touched way becomes 0
  always_comb begin
    touched = rank_q[upd_set][upd_way];
    for (int w = 0; w < WAYS; w++) begin
      if (RW'(w) == upd_way)
        row_d[w] = '0;
      else if (rank_q[upd_set][w] < touched)
        row_d[w] = rank_q[upd_set][w] + 1'b1;
      else
        row_d[w] = rank_q[upd_set][w];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          rank_q[s][w] <= RW'(WAYS - 1 - w);
    end else if (upd_en) begin
      for (int w = 0; w < WAYS; w++)
        rank_q[upd_set][w] <= row_d[w];
    end
  end

  always_comb begin
    for (int w = 0; w < WAYS; w++)
      rd_ranks[w*RW +: RW] = rank_q[rd_set][w];
  end
endmodule

// File: rtl/lfsr16.sv
module lfsr16 #(
  parameter int          OUT_W = 2,
  parameter logic [15:0] SEED  = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [OUT_W-1:0] pick
);
  logic [15:0] state_q, state_d;

  always_comb begin
    state_d = {state_q[14:0], state_q[15] ^ state_q[13] ^ state_q[12] ^ state_q[10]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  assign pick = state_q[OUT_W-1:0];
endmodule

// File: rtl/victim_sel.sv
module victim_sel
  import victim_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  localparam int WW = ($clog2(WAYS) > 0) ? $clog2(WAYS) : 1,
  localparam int SW = ($clog2(SETS) > 0) ? $clog2(SETS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      mode,
  input  logic            acc_valid,
  input  logic [SW-1:0]   acc_set,
  input  logic            hit,
  input  logic [WW-1:0]   hit_way,
  input  logic            fill,
  input  logic [WAYS-1:0] way_valid,
  output logic [WW-1:0]   victim_way
);
  logic [WAYS*WW-1:0] lru_rd;
  logic [WAYS*WW-1:0] fifo_rd;

  if (WAYS == 1) begin : g_dm
    assign victim_way = '0;
    assign lru_rd     = '0;
    assign fifo_rd    = '0;
  end else begin : g_assoc
    logic          lru_en, fifo_en;
    logic [WW-1:0] lru_upd_way;
    logic [WW-1:0] rnd_way, sel_way;
    logic [WW-1:0] inv_way, old_way, new_way, first_way;
    logic          inv_any;
    repl_mode_e    pol;

    lfsr16 #(.OUT_W(WW)) u_lfsr (.clk(clk), .rst_n(rst_n), .pick(rnd_way));

    // touch order: hits and fills
    assign lru_en      = acc_valid & (hit | fill);
    assign lru_upd_way = hit ? hit_way : sel_way;
    // fill order: fills only
    assign fifo_en     = acc_valid & fill & ~hit;

    rank_store #(.WAYS(WAYS), .SETS(SETS)) u_touch (
      .clk(clk), .rst_n(rst_n), .upd_en(lru_en), .upd_set(acc_set),
      .upd_way(lru_upd_way), .rd_set(acc_set), .rd_ranks(lru_rd));

    rank_store #(.WAYS(WAYS), .SETS(SETS)) u_order (
      .clk(clk), .rst_n(rst_n), .upd_en(fifo_en), .upd_set(acc_set),
      .upd_way(sel_way), .rd_set(acc_set), .rd_ranks(fifo_rd));

    always_comb begin
      pol     = repl_mode_e'(mode);
      inv_any = 1'b0;
      inv_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
        if (!way_valid[w]) begin
          inv_any = 1'b1;
          inv_way = WW'(w);
        end
      end
      old_way   = '0;
      new_way   = '0;
      first_way = '0;
      for (int w = 0; w < WAYS; w++) begin
        if (lru_rd[w*WW +: WW] == WW'(WAYS - 1)) old_way   = WW'(w);
        if (lru_rd[w*WW +: WW] == '0)            new_way   = WW'(w);
        if (fifo_rd[w*WW +: WW] == WW'(WAYS - 1)) first_way = WW'(w);
      end
      if (inv_any) begin
        sel_way = inv_way;
      end else begin
        case (pol)
          POL_LRU:  sel_way = old_way;
          POL_MRU:  sel_way = new_way;
          POL_FIFO: sel_way = first_way;
          default:  sel_way = rnd_way;
        endcase
      end
    end

    assign victim_way = sel_way;
  end
endmodule

// File: rtl/victim_sel_chk.sv
module victim_sel_chk #(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  localparam int WW = ($clog2(WAYS) > 0) ? $clog2(WAYS) : 1,
  localparam int SW = ($clog2(SETS) > 0) ? $clog2(SETS) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         mode,
  input logic               acc_valid,
  input logic [SW-1:0]      acc_set,
  input logic               hit,
  input logic [WW-1:0]      hit_way,
  input logic               fill,
  input logic [WAYS-1:0]    way_valid,
  input logic [WW-1:0]      victim_way,
  input logic [WAYS*WW-1:0] lru_rd,
  input logic [WAYS*WW-1:0] fifo_rd
);
  localparam int RANK_SUM = WAYS * (WAYS - 1) / 2;
  int lru_sum;

  always_comb begin
    lru_sum = 0;
    for (int w = 0; w < WAYS; w++) lru_sum += int'(lru_rd[w*WW +: WW]);
  end

  // R2
  invalid_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&way_valid)) |-> !way_valid[victim_way]);

  // R3
  lru_avoid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (WAYS > 1 && acc_valid && hit && mode == 2'd0) |=>
      (!(acc_set == $past(acc_set) && (&way_valid) && mode == 2'd0) ||
       victim_way != $past(hit_way)));

  // R3
  lru_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && (hit || fill)) |=> lru_sum == RANK_SUM);

  // R4
  mru_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (WAYS > 1 && acc_valid && hit && mode == 2'd1) |=>
      (!(acc_set == $past(acc_set) && (&way_valid) && mode == 2'd1) ||
       victim_way == $past(hit_way)));

  // R5
  fifo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && hit) |=>
      (acc_set != $past(acc_set) || fifo_rd == $past(fifo_rd)));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid) |=>
      (acc_set != $past(acc_set) ||
       (lru_rd == $past(lru_rd) && fifo_rd == $past(fifo_rd))));
endmodule

bind victim_sel victim_sel_chk #(.WAYS(WAYS), .SETS(SETS)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .acc_valid(acc_valid),
  .acc_set(acc_set), .hit(hit), .hit_way(hit_way), .fill(fill),
  .way_valid(way_valid), .victim_way(victim_way),
  .lru_rd(lru_rd), .fifo_rd(fifo_rd));

// File: tb/victim_sel_tb.sv
module victim_sel_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode;
  logic       acc_valid;
  logic [3:0] acc_set;
  logic       hit;
  logic [1:0] hit_way;
  logic       fill;
  logic [3:0] way_valid;
  logic [1:0] victim;
  logic       dm_victim;

  int checks = 0;
  int errors = 0;
  int tick   = 0;
  int lru_t  [16][4];
  int fifo_t [16][4];

  always #10 clk = ~clk;

  victim_sel #(.WAYS(4), .SETS(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .acc_valid(acc_valid),
    .acc_set(acc_set), .hit(hit), .hit_way(hit_way), .fill(fill),
    .way_valid(way_valid), .victim_way(victim));

  victim_sel #(.WAYS(1), .SETS(16)) u_dm (
    .clk(clk), .rst_n(rst_n), .mode(mode), .acc_valid(acc_valid),
    .acc_set(acc_set), .hit(hit), .hit_way(1'b0), .fill(fill),
    .way_valid(way_valid[0]), .victim_way(dm_victim));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_victim(input int s, input logic [3:0] v, input int m);
    int best;
    for (int w = 0; w < 4; w++) if (!v[w]) return w;
    best = 0;
    for (int w = 1; w < 4; w++) begin
      if (m == 0 && lru_t[s][w]  < lru_t[s][best])  best = w;
      if (m == 1 && lru_t[s][w]  > lru_t[s][best])  best = w;
      if (m == 2 && fifo_t[s][w] < fifo_t[s][best]) best = w;
    end
    return best;
  endfunction

  // one cycle: drive at falling edge, check, model update after rising edge
  task automatic access(input bit av, input int s, input bit h, input int hw,
                        input bit f, input logic [3:0] v, input int m, input string req);
    int e;
    @(negedge clk);
    acc_valid = av; acc_set = 4'(s); hit = h; hit_way = 2'(hw);
    fill = f; way_valid = v; mode = 2'(m);
    #1;
    e = exp_victim(s, v, m);
    if (m != 3) chk(req, int'(victim), e);
    chk("R1 direct mapped", int'(dm_victim), 0);
    @(posedge clk);
    #1;
    if (av) begin
      if (h) begin
        lru_t[s][hw] = tick; tick++;
      end else if (f) begin
        lru_t[s][e] = tick; fifo_t[s][e] = tick; tick++;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cnt [4];
    rst_n = 1'b0; mode = '0; acc_valid = 1'b0; acc_set = '0; hit = 1'b0;
    hit_way = '0; fill = 1'b0; way_valid = 4'hF;
    for (int s = 0; s < 16; s++)
      for (int w = 0; w < 4; w++) begin
        lru_t[s][w] = w - 4; fifo_t[s][w] = w - 4;
      end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R7 reset order
    for (int s = 0; s < 16; s += 5) begin
      access(0, s, 0, 0, 0, 4'hF, 0, "R7 reset LRU");
      access(0, s, 0, 0, 0, 4'hF, 1, "R7 reset MRU");
      access(0, s, 0, 0, 0, 4'hF, 2, "R7 reset FIFO");
    end

    // R3 / R4 / R5 sweeps over every set
    for (int m = 0; m < 3; m++)
      for (int s = 0; s < 16; s++)
        for (int i = 0; i < 12; i++) begin
          bit h = ((i + s + m) % 3) != 0;
          access(1, s, h, (i * 3 + s + m) % 4, !h, 4'hF, m,
                 m == 0 ? "R3 LRU sweep" : (m == 1 ? "R4 MRU sweep" : "R5 FIFO sweep"));
        end

    // R5 hits do not disturb the fill order
    access(1, 9, 0, 0, 1, 4'hF, 2, "R5 fill");
    for (int k = 0; k < 4; k++) access(1, 9, 1, k, 0, 4'hF, 2, "R5 hits ignored");
    access(0, 9, 0, 0, 0, 4'hF, 2, "R5 after hits");

    // R8 same set, switch policy without clearing
    for (int k = 0; k < 6; k++) access(1, 7, k[0], (k * 3) % 4, !k[0], 4'hF, 0, "R8 build");
    access(0, 7, 0, 0, 0, 4'hF, 2, "R8 switch to FIFO");
    access(0, 7, 0, 0, 0, 4'hF, 1, "R8 switch to MRU");
    access(0, 7, 0, 0, 0, 4'hF, 0, "R8 back to LRU");

    // R9 traffic on set 2 only, then read all sets
    for (int k = 0; k < 8; k++) access(1, 2, k[1], k % 4, !k[1], 4'hF, 0, "R9 set 2 traffic");
    for (int s = 0; s < 16; s++) access(0, s, 0, 0, 0, 4'hF, 0, "R9 other sets");

    // R10 strobes without acc_valid
    for (int k = 0; k < 4; k++) access(0, 11, 1, k, 1, 4'hF, 0, "R10 idle strobes");
    access(0, 11, 0, 0, 0, 4'hF, 1, "R10 MRU unchanged");
    access(0, 11, 0, 0, 0, 4'hF, 2, "R10 FIFO unchanged");

    // R2 every incomplete valid pattern in every mode (random mode checked here too)
    for (int m = 0; m < 4; m++)
      for (int v = 0; v < 15; v++) begin
        int lo;
        lo = 0;
        while (v[lo]) lo++;
        @(negedge clk);
        acc_valid = 1'b0; acc_set = 4'd3; way_valid = 4'(v); mode = 2'(m);
        #1;
        chk("R2 lowest invalid way", int'(victim), lo);
      end
    // R2 fill goes into the invalid way, then it is the newest
    access(1, 4, 0, 0, 1, 4'b1011, 0, "R2 fill invalid");
    access(0, 4, 0, 0, 0, 4'hF, 1, "R2 filled way newest");

    // R6 random distribution
    for (int w = 0; w < 4; w++) cnt[w] = 0;
    for (int k = 0; k < 4096; k++) begin
      @(negedge clk);
      acc_valid = 1'b0; acc_set = 4'd1; way_valid = 4'hF; mode = 2'd3;
      #1;
      cnt[victim]++;
    end
    for (int w = 0; w < 4; w++)
      chk("R6 random share in range", int'(cnt[w] >= 820 && cnt[w] <= 1230), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule